// File: doc/BRIEF.md
# Clock Register File with Periodic Interrupt

This block is the host-facing side of a small real-time-clock register file, reached through two byte ports that share one write-data bus. A write to the index port picks one of fourteen register slots; each later access to the data port reads or writes the slot that was picked. Slots 0 to 9 are plain storage bytes for time and date fields. Nothing inside the block advances them. Slot 10 is a control byte that is read-only in practice, and slot 11 is a control byte that holds the periodic-interrupt enable. Slots 12 and 13 exist only to be rejected.

Illegal use is not silently absorbed. It raises a one-cycle error pulse. Illegal use covers an out-of-range index, a control value the block cannot honour, and any touch of slots 12 or 13. A free-running interval counter runs while the enable bit is set. It produces a one-clock interrupt pulse each time the programmed number of clock cycles has passed.

Top module: `rtc_regfile`

## Requirements
- R1: Reset state: `err`, `irq` and `rd_valid` are low. Slot 10 holds 0x26, which gives 0xA6 on its first read. Slot 11 reads 0x46: bit 6 is the periodic enable, bit 2 is binary mode and bit 1 is 24-hour mode.
- R2: An index-port write with a value above 0x0D pulses `err` one cycle later and leaves the stored index unchanged.
- R3: A data write to slots 0 to 9 stores the byte, and a data read of the same slot returns it.
- R4: A data write to slot 10 never changes it. Any value other than 0x26 pulses `err`, and 0x26 does not.
- R5: Each data read of slot 10 inverts bit 7 of the register and returns the inverted value.
- R6: A data write to slot 11 is accepted only when the written value with bits 6 and 3 cleared equals 0x06. Otherwise `err` pulses and slot 11 keeps its old value.
- R7: A data read or write while slot 12 or 13 is selected pulses `err`. Such a read still returns a result, with value 0x00.
- R8: While bit 6 of slot 11 is set, `irq` pulses high for one cycle every PERIOD clock cycles, counted from reset release.
- R9: Clearing bit 6 of slot 11 stops the pulses. Setting it again from the cleared state gives the first pulse a full PERIOD cycles after the write.
- R10: A data read gives `rd_valid` with `rdata` one cycle after `rd_en`. A read strobe on the index port gives no result. A legal index write raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_data | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_en | input | 1 | Write strobe for the selected port |
| rd_en | input | 1 | Read strobe; it acts only on the data port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid while `rd_valid` is high |
| rd_valid | output | 1 | One-cycle marker for a read result |
| err | output | 1 | One-cycle pulse flagging an illegal access |
| irq | output | 1 | One-cycle periodic interrupt pulse |

## Verification
The hardest situation to create from the ports is the timer restart. The interval counter is invisible from the ports, so "starts from zero on re-enable" can only be seen as the spacing between the enabling write and the next pulse. The stimulus first confirms the cadence from reset. It then clears the enable, holds for several intervals to prove silence, and finally sets the enable again, counting cycles to the first pulse. The self-toggling slot 10 is reached by back-to-back reads, which are interleaved with rejected writes to show that writes leave it alone.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = 4;
  localparam int NUM_MEM = 10;

  localparam logic [DATA_W-1:0] SLOT_CTLA = 8'd10;
  localparam logic [DATA_W-1:0] SLOT_CTLB = 8'd11;
  localparam logic [DATA_W-1:0] SLOT_LAST = 8'd13;

  localparam logic [DATA_W-1:0] CTLA_INIT  = 8'h26; // 32.768 kHz base, 1024 Hz rate
  localparam logic [DATA_W-1:0] CTLB_INIT  = 8'h46; // enable, binary, 24-hour
  localparam logic [DATA_W-1:0] CTLB_WMASK = 8'h48; // enable and square-wave bits
  localparam logic [DATA_W-1:0] CTLB_FIXED = 8'h06; // binary and 24-hour must stay set

  localparam int BUSY_BIT = 7;
  localparam int TICK_BIT = 6;

  typedef enum logic [1:0] {SRC_MEM, SRC_CTLA, SRC_CTLB, SRC_ZERO} rd_src_e;
endpackage

// File: rtl/rtc_store.sv
module rtc_store #(
  parameter int DEPTH = 10,
  parameter int WIDTH = 8,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Synchronous write and registered read, so that block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= din;
    if (re) dout <= mem[addr];
  end
endmodule

// File: rtl/rtc_ctl.sv
module rtc_ctl
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  input  logic              dwr,
  input  logic              drd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl_a,
  output logic [DATA_W-1:0] ctl_b,
  output logic              bad_wr
);
  logic sel_a, sel_b, a_bad, b_bad;

  assign sel_a  = ({4'd0, idx} == SLOT_CTLA);
  assign sel_b  = ({4'd0, idx} == SLOT_CTLB);
  assign a_bad  = dwr && sel_a && (wdata != CTLA_INIT);
  assign b_bad  = dwr && sel_b && ((wdata & ~CTLB_WMASK) != CTLB_FIXED);
  assign bad_wr = a_bad || b_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_a <= CTLA_INIT;
      ctl_b <= CTLB_INIT;
    end else begin
      if (drd && sel_a) ctl_a[BUSY_BIT] <= ~ctl_a[BUSY_BIT];
      if (dwr && sel_b && !b_bad) ctl_b <= wdata;
    end
  end
endmodule

// File: rtl/rtc_tick.sv
module rtc_tick #(
  parameter int PERIOD = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic pulse
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (!en) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      pulse <= 1'b1;
    end else begin
      cnt   <= cnt + 1'b1;
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int PERIOD = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_data,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              err,
  output logic              irq
);
  localparam int MAW = $clog2(NUM_MEM);

  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] idx_ext;
  logic              iwr, dwr, drd, in_mem, reserved, bad_idx, ctl_bad;
  logic [DATA_W-1:0] ctl_a, ctl_b, mem_q;
  rd_src_e           src_q;

  assign idx_ext  = {{(DATA_W-IDX_W){1'b0}}, idx_q};
  assign iwr      = wr_en && !sel_data;
  assign dwr      = wr_en && sel_data;
  assign drd      = rd_en && sel_data;
  assign in_mem   = idx_ext < DATA_W'(NUM_MEM);
  assign reserved = idx_ext > SLOT_CTLB;
  assign bad_idx  = iwr && (wdata > SLOT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      err      <= 1'b0;
      rd_valid <= 1'b0;
      src_q    <= SRC_ZERO;
    end else begin
      if (iwr && !bad_idx) idx_q <= wdata[IDX_W-1:0];
      err      <= bad_idx || ctl_bad || ((dwr || drd) && reserved);
      rd_valid <= drd;
      if (drd) begin
        if (in_mem)                  src_q <= SRC_MEM;
        else if (idx_ext == SLOT_CTLA) src_q <= SRC_CTLA;
        else if (idx_ext == SLOT_CTLB) src_q <= SRC_CTLB;
        else                         src_q <= SRC_ZERO;
      end
    end
  end

  rtc_store #(.DEPTH(NUM_MEM), .WIDTH(DATA_W), .AW(MAW)) u_store (
    .clk (clk),
    .we  (dwr && in_mem),
    .re  (drd && in_mem),
    .addr(idx_q[MAW-1:0]),
    .din (wdata),
    .dout(mem_q)
  );

  rtc_ctl u_ctl (
    .clk   (clk),
    .rst   (rst),
    .idx   (idx_q),
    .dwr   (dwr),
    .drd   (drd),
    .wdata (wdata),
    .ctl_a (ctl_a),
    .ctl_b (ctl_b),
    .bad_wr(ctl_bad)
  );

  rtc_tick #(.PERIOD(PERIOD)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (ctl_b[TICK_BIT]),
    .pulse(irq)
  );

  always_comb begin
    unique case (src_q)
      SRC_MEM:  rdata = mem_q;
      SRC_CTLA: rdata = ctl_a;
      SRC_CTLB: rdata = ctl_b;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk (
  input logic       clk,
  input logic       rst,
  input logic       sel_data,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic       rd_valid,
  input logic       err,
  input logic       irq,
  input logic [3:0] idx,
  input logic [7:0] ctl_a,
  input logic       tick_en
);
  p_bad_index_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sel_data && wdata > 8'd13) |=> err);

  p_ctla_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && sel_data && idx == 4'd10) |=> $stable(ctl_a));

  p_ctla_flip_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel_data && idx == 4'd10) |=> (ctl_a == ($past(ctl_a) ^ 8'h80)));

  p_reserved_r7: assert property (@(posedge clk) disable iff (rst)
    ((rd_en || wr_en) && sel_data && idx >= 4'd12) |=> err);

  p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_quiet_off_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(tick_en) |-> !irq);

  p_rd_valid_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel_data) |=> rd_valid);

  p_no_rd_valid_r10: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && sel_data) |=> !rd_valid);
endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .sel_data(sel_data),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .wdata   (wdata),
  .rd_valid(rd_valid),
  .err     (err),
  .irq     (irq),
  .idx     (idx_q),
  .ctl_a   (ctl_a),
  .tick_en (ctl_b[6])
);

// File: tb/rtc_regfile_test.sv
module rtc_regfile_test;
  localparam int PER = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_data = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rd_valid, err, irq;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  rtc_regfile #(.PERIOD(PER)) uut (
    .clk(clk), .rst(rst), .sel_data(sel_data), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .err(err), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as results appear.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected read result", rdata, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string      t = tag_q.pop_front();
        check(rdata == e, t, rdata, e);
      end
    end
  end

  task automatic put(input logic sel, input logic [7:0] d, input logic e_err, input string tag);
    @(negedge clk);
    sel_data = sel; wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    check(err == e_err, tag, err, e_err);
  endtask

  task automatic get(input logic [7:0] e_data, input logic e_err, input string tag);
    exp_q.push_back(e_data);
    tag_q.push_back(tag);
    @(negedge clk);
    sel_data = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(err == e_err, tag, err, e_err);
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int first, second, pulses, gap;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(err == 0 && irq == 0 && rd_valid == 0, "R1 reset outputs", {err, irq, rd_valid}, 0);

    // R8: cadence from reset release
    first = 0; second = 0; pulses = 0;
    for (int n = 1; n <= 45; n++) begin
      @(negedge clk);
      if (irq) begin
        pulses++;
        if (first == 0) first = n; else if (second == 0) second = n;
      end
    end
    check(first == PER, "R8 first pulse cycle", first, PER);
    check(second == 2 * PER, "R8 second pulse cycle", second, 2 * PER);
    check(pulses == 2, "R8 pulse count single-cycle", pulses, 2);

    // R1/R5 slot 10
    put(1'b0, 8'd10, 1'b0, "R10 legal index write");
    get(8'hA6, 1'b0, "R1 R5 first ctl A read");
    get(8'h26, 1'b0, "R5 second ctl A read");
    put(1'b1, 8'h26, 1'b0, "R4 matching ctl A write");
    put(1'b1, 8'h30, 1'b1, "R4 mismatching ctl A write");
    get(8'hA6, 1'b0, "R4 ctl A unchanged");

    // R3 storage
    put(1'b0, 8'd3, 1'b0, "R3 index 3");
    put(1'b1, 8'h5A, 1'b0, "R3 write slot 3");
    put(1'b0, 8'd9, 1'b0, "R3 index 9");
    put(1'b1, 8'hC3, 1'b0, "R3 write slot 9");
    put(1'b0, 8'd0, 1'b0, "R3 index 0");
    put(1'b1, 8'h11, 1'b0, "R3 write slot 0");
    get(8'h11, 1'b0, "R3 read slot 0");
    put(1'b0, 8'd9, 1'b0, "R3 index 9 again");
    get(8'hC3, 1'b0, "R3 read slot 9");
    put(1'b0, 8'd3, 1'b0, "R3 index 3 again");
    get(8'h5A, 1'b0, "R3 read slot 3");

    // R2 out-of-range index
    put(1'b0, 8'h0E, 1'b1, "R2 index 0x0E");
    put(1'b0, 8'hFF, 1'b1, "R2 index 0xFF");
    get(8'h5A, 1'b0, "R2 index kept");

    // R7 reserved slots
    put(1'b0, 8'd13, 1'b0, "R10 index 13 accepted");
    get(8'h00, 1'b1, "R7 read slot 13");
    put(1'b0, 8'd12, 1'b0, "R10 index 12 accepted");
    put(1'b1, 8'h55, 1'b1, "R7 write slot 12");

    // R6 slot 11
    put(1'b0, 8'd11, 1'b0, "R6 index 11");
    get(8'h46, 1'b0, "R1 ctl B reset value");
    put(1'b1, 8'h07, 1'b1, "R6 illegal ctl B write");
    get(8'h46, 1'b0, "R6 ctl B unchanged");
    put(1'b1, 8'h4E, 1'b0, "R6 legal ctl B write");
    get(8'h4E, 1'b0, "R6 ctl B updated");

    // R10 index-port read is ignored
    @(negedge clk);
    sel_data = 1'b0; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_valid == 0, "R10 index port read ignored", rd_valid, 0);

    // R9 disable then re-enable
    put(1'b1, 8'h0E, 1'b0, "R9 clear enable");
    @(negedge clk);
    pulses = 0;
    for (int n = 0; n < 3 * PER; n++) begin
      @(negedge clk);
      if (irq) pulses++;
    end
    check(pulses == 0, "R9 no pulses while disabled", pulses, 0);
    get(8'h0E, 1'b0, "R9 ctl B reads disabled");
    put(1'b1, 8'h46, 1'b0, "R9 set enable");
    gap = 0;
    for (int n = 1; n <= 3 * PER; n++) begin
      @(negedge clk);
      if (irq && gap == 0) gap = n;
    end
    check(gap == PER, "R9 restart interval", gap, PER);

    check(exp_q.size() == 0, "R10 all reads answered", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule